// File: doc/BRIEF.md
# User-Mode Trap CSR Unit

This block keeps the user-level trap registers of a processor core: a status word carrying the interrupt-enable bit, a cause register, a saved exception PC, a trap-vector base and a scratch word. These registers sit outside the general register file. Software reaches them only through the block's CSR command port. Each command returns the register's previous value and, in the same step, replaces, sets bits in or clears bits in that register. The operand is either a full-width source register or a zero-extended 5-bit immediate.

The block also steers control flow. When the core reports an exception while interrupts are enabled, the block records the cause and the word-aligned faulting PC, then requests a jump to the trap vector. A return command requests a jump to whatever the saved exception PC holds at that moment. A handler can therefore move the resume point, for example past the faulting instruction. The core uses the read value, the illegal-access flag and the redirect pair.

Top module: `utrap_csr_unit`

## Requirements
- R1: After reset every register reads zero, interrupts are disabled, and both `redir_valid` and `csr_illegal` are low.
- R2: Addresses: 0x000 status (only bit 0, the interrupt enable, is stored; other bits read zero), 0x005 trap vector, 0x040 scratch, 0x041 exception PC, 0x042 cause. `csr_op` encodes 0 read-write, 1 read-set, 2 read-clear, 3 read-only. During the command cycle `csr_rdata` shows the register's value from before the command.
- R3: Read-write replaces the register with the operand from the next cycle on.
- R4: Read-set writes the old value ORed with the operand.
- R5: Read-clear writes the old value ANDed with the inverted operand.
- R6: With `csr_use_imm` high, the operand is `csr_uimm` zero-extended to the data width, and `csr_src` is ignored.
- R7: With `csr_rd_zero` high, `csr_rdata` reads zero but the write still takes effect.
- R8: Read-set or read-clear with a zero operand, and read-only with any operand, leave the register unchanged.
- R9: Bits 1:0 of the trap vector and of the exception PC are always stored as zero, both on CSR writes and on exception capture.
- R10: A command to any other address returns zero, changes no register, and raises `csr_illegal` in that same cycle only.
- R11: An exception with the enable bit set stores `exc_pc` with bits 1:0 cleared and `exc_cause`. In the next cycle it raises `redir_valid` for one cycle, with `redir_pc` equal to the trap vector. A CSR write in the same cycle is dropped. The exception takes priority over a return.
- R12: An exception with the enable bit clear is ignored: no redirect, and the cause and exception PC are unchanged.
- R13: A return command raises `redir_valid` in the next cycle, with `redir_pc` equal to the exception PC as it stood in the command cycle, including any value software wrote earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously upstream |
| csr_valid | input | 1 | CSR command present |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 write, 1 set, 2 clear, 3 read-only |
| csr_use_imm | input | 1 | Select immediate operand |
| csr_src | input | XLEN | Register operand |
| csr_uimm | input | 5 | Immediate operand |
| csr_rd_zero | input | 1 | Destination is register zero |
| exc_valid | input | 1 | Exception request |
| exc_cause | input | XLEN | Exception cause code |
| exc_pc | input | XLEN | Faulting instruction address |
| ret_valid | input | 1 | Return-from-handler command |
| csr_rdata | output | XLEN | Previous register value |
| csr_illegal | output | 1 | Unimplemented address accessed |
| redir_valid | output | 1 | Program counter redirect request |
| redir_pc | output | XLEN | Redirect target |

## Verification
The read value and the illegal flag depend combinationally on the command. Each is due in the command's own cycle. A register update is visible to a command issued one cycle later. A redirect appears exactly one clock after its exception or return and lasts that one cycle. The bench drives every input on the falling edge and samples a quarter period later, before the next rising edge. Each check therefore sees the command-cycle value or the value one register stage later, never a value in transition.

// File: rtl/utrap_pkg.sv
package utrap_pkg;

  localparam int unsigned CSR_AW  = 12;
  localparam int unsigned NUM_CSR = 5;

  typedef enum logic [1:0] {
    CSR_RW = 2'd0,
    CSR_RS = 2'd1,
    CSR_RC = 2'd2,
    CSR_RD = 2'd3
  } csr_op_e;

  // register slot indices
  localparam int unsigned IX_STATUS  = 0;
  localparam int unsigned IX_TVEC    = 1;
  localparam int unsigned IX_SCRATCH = 2;
  localparam int unsigned IX_EPC     = 3;
  localparam int unsigned IX_CAUSE   = 4;

  localparam logic [CSR_AW-1:0] CSR_MAP [NUM_CSR] = '{
    12'h000, 12'h005, 12'h040, 12'h041, 12'h042
  };

endpackage

// File: rtl/utrap_csr_decode.sv
module utrap_csr_decode
  import utrap_pkg::*;
#(
  parameter int unsigned NUM = NUM_CSR
) (
  input  logic [CSR_AW-1:0] addr,
  output logic [NUM-1:0]    sel,
  output logic              hit
);

  for (genvar i = 0; i < NUM; i++) begin : g_match
    assign sel[i] = (addr == CSR_MAP[i]);
  end

  assign hit = |sel;

endmodule

// File: rtl/utrap_csr_alu.sv
module utrap_csr_alu
  import utrap_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 5
) (
  input  logic [XLEN-1:0]  old_val,
  input  logic [XLEN-1:0]  src,
  input  logic [IMM_W-1:0] uimm,
  input  logic             use_imm,
  input  csr_op_e          op,
  output logic [XLEN-1:0]  new_val,
  output logic             wr_req
);

  logic [XLEN-1:0] operand;

  always_comb begin
    operand = use_imm ? {{(XLEN-IMM_W){1'b0}}, uimm} : src;
    new_val = old_val;
    wr_req  = 1'b0;
    unique case (op)
      CSR_RW: begin
        new_val = operand;
        wr_req  = 1'b1;
      end
      CSR_RS: begin
        new_val = old_val | operand;
        wr_req  = |operand;
      end
      CSR_RC: begin
        new_val = old_val & ~operand;
        wr_req  = |operand;
      end
      default: begin
        new_val = old_val;
        wr_req  = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/utrap_csr_unit.sv
module utrap_csr_unit
  import utrap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_valid,
  input  logic [11:0]       csr_addr,
  input  logic [1:0]        csr_op,
  input  logic              csr_use_imm,
  input  logic [XLEN-1:0]   csr_src,
  input  logic [4:0]        csr_uimm,
  input  logic              csr_rd_zero,
  input  logic              exc_valid,
  input  logic [XLEN-1:0]   exc_cause,
  input  logic [XLEN-1:0]   exc_pc,
  input  logic              ret_valid,
  output logic [XLEN-1:0]   csr_rdata,
  output logic              csr_illegal,
  output logic              redir_valid,
  output logic [XLEN-1:0]   redir_pc
);

  localparam int unsigned IMM_W = 5;
  localparam logic [XLEN-1:0] WORD_MASK = ~{{(XLEN-2){1'b0}}, 2'b11};

  logic [NUM_CSR-1:0]            sel;
  logic                          hit;
  logic [NUM_CSR-1:0][XLEN-1:0]  csr_vec;
  logic [XLEN-1:0]               old_val;
  logic [XLEN-1:0]               new_val;
  logic                          wr_req;
  logic                          exc_take;
  logic                          csr_wr;

  utrap_csr_decode #(.NUM(NUM_CSR)) u_decode (
    .addr (csr_addr),
    .sel  (sel),
    .hit  (hit)
  );

  // previous value of the addressed register
  always_comb begin
    old_val = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (sel[i]) old_val = old_val | csr_vec[i];
    end
  end

  utrap_csr_alu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_alu (
    .old_val (old_val),
    .src     (csr_src),
    .uimm    (csr_uimm),
    .use_imm (csr_use_imm),
    .op      (csr_op_e'(csr_op)),
    .new_val (new_val),
    .wr_req  (wr_req)
  );

  assign exc_take = exc_valid && csr_vec[IX_STATUS][0];
  assign csr_wr   = csr_valid && hit && wr_req && !exc_take;

  // one register per slot, each with its own write mask and enable
  for (genvar i = 0; i < NUM_CSR; i++) begin : g_reg
    localparam logic [XLEN-1:0] KEEP =
      (i == IX_STATUS) ? {{(XLEN-1){1'b0}}, 1'b1} :
      ((i == IX_TVEC) || (i == IX_EPC)) ? WORD_MASK : '1;
    localparam bit CAPTURES = (i == IX_EPC) || (i == IX_CAUSE);

    logic [XLEN-1:0] q, d;
    logic            en;

    always_comb begin
      en = 1'b0;
      d  = q;
      if (CAPTURES && exc_take) begin
        en = 1'b1;
        d  = (i == IX_EPC) ? (exc_pc & KEEP) : exc_cause;
      end else if (csr_wr && sel[i]) begin
        en = 1'b1;
        d  = new_val & KEEP;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign csr_vec[i] = q;
  end

  assign csr_rdata   = (csr_valid && !csr_rd_zero) ? old_val : '0;
  assign csr_illegal = csr_valid && !hit;

  // redirect stage
  logic            redir_v_d;
  logic [XLEN-1:0] redir_pc_d;

  always_comb begin
    redir_v_d  = exc_take || ret_valid;
    redir_pc_d = exc_take ? csr_vec[IX_TVEC] : csr_vec[IX_EPC];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
    end else begin
      redir_valid <= redir_v_d;
      if (redir_v_d) redir_pc <= redir_pc_d;
    end
  end

  // ---------------- assertions ----------------
  a_r10_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && !hit && !exc_valid |=> $stable(csr_vec));

  a_r8_zero_set_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid && (csr_op == 2'd1) && !csr_use_imm && (csr_src == '0) && !exc_valid
    |=> $stable(csr_vec));

  a_r12_disabled_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid && !csr_vec[IX_STATUS][0] && !ret_valid |=> !redir_valid);

  a_r11_trap_target: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take |=> redir_valid && (redir_pc == $past(csr_vec[IX_TVEC])));

  a_r13_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid && !exc_take |=> redir_valid && (redir_pc == $past(csr_vec[IX_EPC])));

  a_r9_redirect_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (redir_pc[1:0] == 2'b00));

  a_r2_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

endmodule

// File: tb/utrap_csr_unit_bench.sv
module utrap_csr_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 18;
  localparam int VW         = 86;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_valid, csr_use_imm, csr_rd_zero, exc_valid, ret_valid;
  logic [11:0] csr_addr;
  logic [1:0]  csr_op;
  logic [31:0] csr_src, exc_cause, exc_pc;
  logic [4:0]  csr_uimm;
  logic [31:0] csr_rdata, redir_pc;
  logic        csr_illegal, redir_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utrap_csr_unit u_utrap_csr_unit (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_addr(csr_addr),
    .csr_op(csr_op), .csr_use_imm(csr_use_imm), .csr_src(csr_src),
    .csr_uimm(csr_uimm), .csr_rd_zero(csr_rd_zero), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .exc_pc(exc_pc), .ret_valid(ret_valid),
    .csr_rdata(csr_rdata), .csr_illegal(csr_illegal),
    .redir_valid(redir_valid), .redir_pc(redir_pc)
  );

  // {addr, op, imm, src, uimm, rd_zero, expected rdata, expected illegal}
  localparam logic [VW-1:0] VEC [NVEC] = '{
    {12'h040, 2'd1, 1'b0, 32'h0000_0000, 5'h00, 1'b0, 32'h0000_0000, 1'b0}, // R2 read scratch
    {12'h040, 2'd0, 1'b0, 32'hA5A5_0F0F, 5'h00, 1'b0, 32'h0000_0000, 1'b0}, // R3 write
    {12'h040, 2'd1, 1'b0, 32'h0000_F0F0, 5'h00, 1'b0, 32'hA5A5_0F0F, 1'b0}, // R4 set
    {12'h040, 2'd2, 1'b0, 32'h0000_00FF, 5'h00, 1'b0, 32'hA5A5_FFFF, 1'b0}, // R5 clear
    {12'h040, 2'd1, 1'b1, 32'hFFFF_FFFF, 5'h13, 1'b0, 32'hA5A5_FF00, 1'b0}, // R6 set imm
    {12'h040, 2'd2, 1'b1, 32'hFFFF_FFFF, 5'h03, 1'b0, 32'hA5A5_FF13, 1'b0}, // R6 clear imm
    {12'h040, 2'd0, 1'b0, 32'h1234_5678, 5'h00, 1'b1, 32'h0000_0000, 1'b0}, // R7 rd zero
    {12'h040, 2'd1, 1'b0, 32'h0000_0000, 5'h00, 1'b0, 32'h1234_5678, 1'b0}, // R7 write landed
    {12'h005, 2'd0, 1'b0, 32'h0000_1003, 5'h00, 1'b0, 32'h0000_0000, 1'b0}, // R9 tvec
    {12'h005, 2'd1, 1'b0, 32'h0000_0000, 5'h00, 1'b0, 32'h0000_1000, 1'b0}, // R9 aligned
    {12'h041, 2'd0, 1'b0, 32'h0000_2007, 5'h00, 1'b0, 32'h0000_0000, 1'b0}, // R9 epc
    {12'h041, 2'd3, 1'b0, 32'hFFFF_FFFF, 5'h00, 1'b0, 32'h0000_2004, 1'b0}, // R8 read-only
    {12'h041, 2'd2, 1'b1, 32'hFFFF_FFFF, 5'h00, 1'b0, 32'h0000_2004, 1'b0}, // R8 zero clear
    {12'h123, 2'd0, 1'b0, 32'hFFFF_FFFF, 5'h00, 1'b0, 32'h0000_0000, 1'b1}, // R10 illegal
    {12'h000, 2'd1, 1'b1, 32'h0000_0000, 5'h1F, 1'b0, 32'h0000_0000, 1'b0}, // R2 status set
    {12'h000, 2'd1, 1'b0, 32'h0000_0000, 5'h00, 1'b0, 32'h0000_0001, 1'b0}, // R2 bit0 only
    {12'h042, 2'd0, 1'b0, 32'h0000_000B, 5'h00, 1'b0, 32'h0000_0000, 1'b0}, // R3 cause
    {12'h042, 2'd1, 1'b0, 32'h0000_0000, 5'h00, 1'b0, 32'h0000_000B, 1'b0}  // R3 cause kept
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    csr_valid = 1'b0; exc_valid = 1'b0; ret_valid = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  task automatic drive(input logic [11:0] a, input logic [1:0] o, input logic im,
                       input logic [31:0] s, input logic [4:0] u, input logic rz);
    @(negedge clk);
    csr_valid = 1'b1; csr_addr = a; csr_op = o; csr_use_imm = im;
    csr_src = s; csr_uimm = u; csr_rd_zero = rz;
    exc_valid = 1'b0; ret_valid = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  task automatic read_chk(input string tag, input logic [11:0] a, input logic [31:0] exp);
    drive(a, 2'd1, 1'b0, 32'h0, 5'h0, 1'b0);
    check(tag, csr_rdata, exp);
  endtask

  task automatic raise(input logic e, input logic r, input logic [31:0] c, input logic [31:0] p);
    @(negedge clk);
    csr_valid = 1'b0; exc_valid = e; ret_valid = r; exc_cause = c; exc_pc = p;
    #(CLK_PERIOD/4);
  endtask

  initial begin
    rst_n = 1'b0; csr_valid = 1'b0; csr_addr = '0; csr_op = '0; csr_use_imm = 1'b0;
    csr_src = '0; csr_uimm = '0; csr_rd_zero = 1'b0; exc_valid = 1'b0;
    exc_cause = '0; exc_pc = '0; ret_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check("R1 redir_valid after reset", {31'b0, redir_valid}, 32'h0);
    check("R1 illegal after reset", {31'b0, csr_illegal}, 32'h0);
    read_chk("R1 status after reset", 12'h000, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][85:74], VEC[i][73:72], VEC[i][71], VEC[i][70:39], VEC[i][38:34], VEC[i][33]);
      check($sformatf("R2-table vector %0d rdata", i), csr_rdata, VEC[i][32:1]);
      check($sformatf("R10 table vector %0d illegal", i), {31'b0, csr_illegal}, {31'b0, VEC[i][0]});
    end

    // R11: taken exception with a colliding CSR write
    @(negedge clk);
    exc_valid = 1'b1; exc_cause = 32'h5; exc_pc = 32'h0000_3002;
    csr_valid = 1'b1; csr_addr = 12'h040; csr_op = 2'd0; csr_use_imm = 1'b0;
    csr_src = 32'hDEAD_BEEF; csr_rd_zero = 1'b0;
    idle();
    check("R11 redirect valid", {31'b0, redir_valid}, 32'h1);
    check("R11 redirect to vector", redir_pc, 32'h0000_1000);
    read_chk("R11 epc captured aligned", 12'h041, 32'h0000_3000);
    check("R11 redirect one cycle", {31'b0, redir_valid}, 32'h0);
    read_chk("R11 cause captured", 12'h042, 32'h5);
    read_chk("R11 colliding write dropped", 12'h040, 32'h1234_5678);

    // R13: handler skips the faulting word, then returns
    drive(12'h041, 2'd0, 1'b0, 32'h0000_3004, 5'h0, 1'b0);
    check("R13 epc old value", csr_rdata, 32'h0000_3000);
    raise(1'b0, 1'b1, 32'h0, 32'h0);
    idle();
    check("R13 return valid", {31'b0, redir_valid}, 32'h1);
    check("R13 return target", redir_pc, 32'h0000_3004);

    // R12: disabled exceptions are ignored
    drive(12'h000, 2'd2, 1'b1, 32'h0, 5'h01, 1'b0);
    check("R12 status before clear", csr_rdata, 32'h1);
    raise(1'b1, 1'b0, 32'h7, 32'h0000_4000);
    idle();
    check("R12 no redirect", {31'b0, redir_valid}, 32'h0);
    read_chk("R12 epc unchanged", 12'h041, 32'h0000_3004);
    read_chk("R12 cause unchanged", 12'h042, 32'h5);

    // R11: exception beats a same-cycle return
    drive(12'h000, 2'd0, 1'b1, 32'h0, 5'h01, 1'b0);
    raise(1'b1, 1'b1, 32'h9, 32'h0000_5000);
    idle();
    check("R11 priority valid", {31'b0, redir_valid}, 32'h1);
    check("R11 priority target", redir_pc, 32'h0000_1000);
    read_chk("R11 priority cause", 12'h042, 32'h9);

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0; csr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #(CLK_PERIOD/4);
    check("R1 redirect cleared", {31'b0, redir_valid}, 32'h0);
    read_chk("R1 scratch cleared", 12'h040, 32'h0);
    read_chk("R1 tvec cleared", 12'h005, 32'h0);
    idle();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule